// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and brings the memory from power-on to an operational state. After reset it keeps the clock enable low and the device deselected for a programmable stable-clock interval. It then raises the clock enable, waits a short settling gap, and issues a fixed series of commands: a precharge of all banks, a load of the extended mode register that turns the DLL on, a load of the main mode register that resets the DLL, a second precharge of all banks, a programmable number of auto-refreshes, and a final load of the main mode register without the DLL reset.

Every wait is a parameter counted in clock cycles, so a system at 100 MHz uses 20000 cycles for the 200 us stable-clock interval and a test can use far fewer. Each command is followed by its own minimum gap before the next one. The done flag rises only when the final mode load has had its gap and the DLL has had its full lock time since it was reset. After that the outputs stay on NOP until the next reset, and normal traffic can take over.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset, the clock enable is low and the bus carries deselect ({cs_n,ras_n,cas_n,we_n} = 1111, bank and address zero) for exactly T_STABLE cycles; the clock enable is first high in cycle T_STABLE after reset release.
- R2: Once high, the clock enable stays high until reset; the first T_CKE cycles with it high carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111, bank and address zero).
- R3: Commands appear in this order: precharge (0010), extended mode load, mode load with DLL reset, precharge, N_REF refreshes (0001), final mode load; mode loads use 0000.
- R4: Both precharges drive address bit 10 high and all other address and bank bits low.
- R5: The extended mode load drives bank = 01 (bank bit 0 high), address bit 0 low (DLL on), address bit 1 = HALF_DRIVE, and all other address bits low, bit 2 included.
- R6: Both main mode loads drive bank = 00, address bits 6..4 = 011 (read latency 3), bit 3 = BURST_TYPE, bits 2..0 = 001/010/011 for a burst of 2/4/8; bit 8 is high on the first and low on the final one; all other bits are low.
- R7: The next command follows a precharge after exactly T_RP cycles, a mode or extended mode load after exactly T_MRD cycles, and a refresh after exactly T_RFC cycles.
- R8: The done flag first rises in cycle max(F + T_MRD, D + T_DLL), where F is the cycle of the final mode load and D the cycle of the DLL-reset mode load, and then stays high.
- R9: Every cycle with the clock enable high that carries none of the above commands, including all cycles after done, carries NOP.
- R10: Asserting reset at any point forces clock enable low, deselect and done low at once, and after release the whole sequence runs again from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr_cke | output | 1 | Clock enable to the memory |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank address; bit 0 selects the extended mode register on a mode load |
| ddr_addr | output | ADDR_W | Address bus, carrying the mode words and the precharge-all bit |
| init_done | output | 1 | High once the memory is ready for normal traffic |

## Verification
The bound checker watches every cycle for the clock enable never dropping after it rises, deselect whenever it is low, the precharge-all bit on each precharge, the reserved and DLL-enable bits of the extended mode word, the latency field of each mode word, done staying high and quiet, and, through its own counters, that the clock enable did not rise before the stable interval and done did not rise before the DLL lock time. The exact command order, the exact gaps between commands, the burst and drive-strength fields, the exact cycle done rises, and the restart after a mid-sequence reset are shown only by the bench's scoreboard, which runs two configurations: one where the DLL lock time sets the done cycle and one where the final mode gap does.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // Command encoding on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE  = 4'b0000,
        CMD_REFR  = 4'b0001,
        CMD_PRECH = 4'b0010,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } ddr_cmd_e;

    // Sequencer phase
    typedef enum logic [1:0] {
        PH_STABLE = 2'd0,
        PH_CKE    = 2'd1,
        PH_GAP    = 2'd2,
        PH_DONE   = 2'd3
    } init_phase_e;

    // Command steps, in issue order
    typedef enum logic [2:0] {
        STEP_PRE_A   = 3'd0,
        STEP_EXT     = 3'd1,
        STEP_DLL_RST = 3'd2,
        STEP_PRE_B   = 3'd3,
        STEP_REFRESH = 3'd4,
        STEP_FINAL   = 3'd5
    } init_step_e;

    localparam logic [2:0] LAT3_CODE = 3'b011;

endpackage

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int BURST_LEN  = 4,
    parameter int BURST_TYPE = 0,
    parameter int HALF_DRIVE = 0
) (
    input  init_step_e        step_i,
    output ddr_cmd_e          cmd_o,
    output logic [1:0]        ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int PRE_ALL_BIT = 10;
    localparam int DLL_RST_BIT = 8;

    logic [2:0] len_code;

    generate
        if (BURST_LEN == 8) begin : g_len8
            assign len_code = 3'b011;
        end else if (BURST_LEN == 4) begin : g_len4
            assign len_code = 3'b010;
        end else begin : g_len2
            assign len_code = 3'b001;
        end
    endgenerate

    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = 2'b00;
        addr_o = '0;
        case (step_i)
            STEP_PRE_A, STEP_PRE_B: begin
                cmd_o               = CMD_PRECH;
                addr_o[PRE_ALL_BIT] = 1'b1;
            end
            STEP_EXT: begin
                cmd_o     = CMD_MODE;
                ba_o      = 2'b01;
                addr_o[0] = 1'b0;
                addr_o[1] = 1'(HALF_DRIVE);
            end
            STEP_DLL_RST, STEP_FINAL: begin
                cmd_o               = CMD_MODE;
                addr_o[2:0]         = len_code;
                addr_o[3]           = 1'(BURST_TYPE);
                addr_o[6:4]         = LAT3_CODE;
                addr_o[DLL_RST_BIT] = (step_i == STEP_DLL_RST);
            end
            STEP_REFRESH: begin
                cmd_o = CMD_REFR;
            end
            default: begin
                cmd_o = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_dll_wait.sv
module ddr_init_dll_wait #(
    parameter int T_DLL = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ready_o
);

    localparam int CW = (T_DLL > 1) ? $clog2(T_DLL + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(T_DLL - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } dll_t;

    dll_t dll_d, dll_q;

    always_comb begin
        dll_d = dll_q;
        if (start_i) begin
            dll_d.run = 1'b1;
            dll_d.cnt = '0;
        end else if (dll_q.run && (dll_q.cnt != LAST)) begin
            dll_d.cnt = dll_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dll_q <= '0;
        end else begin
            dll_q <= dll_d;
        end
    end

    assign ready_o = dll_q.run && (dll_q.cnt == LAST);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int T_STABLE   = 20000,
    parameter int T_CKE      = 2,
    parameter int T_RP       = 3,
    parameter int T_MRD      = 2,
    parameter int T_RFC      = 7,
    parameter int T_DLL      = 200,
    parameter int N_REF      = 2,
    parameter int BURST_LEN  = 4,
    parameter int BURST_TYPE = 0,
    parameter int HALF_DRIVE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ddr_cke,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [1:0]        ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              init_done
);

    localparam int MAX_A = (T_STABLE > T_CKE) ? T_STABLE : T_CKE;
    localparam int MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_C = (MAX_B > T_RFC) ? MAX_B : T_RFC;
    localparam int MAX_T = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam int REF_W = (N_REF > 1) ? $clog2(N_REF + 1) : 1;

    localparam logic [CNT_W-1:0] STABLE_LAST = CNT_W'(T_STABLE - 1);
    localparam logic [CNT_W-1:0] CKE_LAST    = CNT_W'(T_CKE - 1);
    localparam logic [CNT_W-1:0] RP_LAST     = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] MRD_LAST    = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] RFC_LAST    = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] CNT_TOP     = '1;
    localparam logic [REF_W-1:0] REF_LAST    = REF_W'(N_REF - 1);

    typedef struct packed {
        init_phase_e       phase;
        init_step_e        step;
        logic [CNT_W-1:0]  cnt;
        logic [REF_W-1:0]  refs;
        logic              cke;
        ddr_cmd_e          cmd;
        logic [1:0]        ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              issue_en;
    init_step_e        issue_step;
    logic [CNT_W-1:0]  gap_last;
    ddr_cmd_e          enc_cmd;
    logic [1:0]        enc_ba;
    logic [ADDR_W-1:0] enc_addr;
    logic              dll_ready;

    // Decide whether a command goes out on the next edge, and which one
    always_comb begin
        case (seq_q.step)
            STEP_PRE_A, STEP_PRE_B: gap_last = RP_LAST;
            STEP_REFRESH:           gap_last = RFC_LAST;
            default:                gap_last = MRD_LAST;
        endcase

        issue_en   = 1'b0;
        issue_step = STEP_PRE_A;
        case (seq_q.phase)
            PH_CKE: begin
                if (seq_q.cnt == CKE_LAST) begin
                    issue_en   = 1'b1;
                    issue_step = STEP_PRE_A;
                end
            end
            PH_GAP: begin
                if (seq_q.cnt >= gap_last) begin
                    case (seq_q.step)
                        STEP_PRE_A: begin
                            issue_en   = 1'b1;
                            issue_step = STEP_EXT;
                        end
                        STEP_EXT: begin
                            issue_en   = 1'b1;
                            issue_step = STEP_DLL_RST;
                        end
                        STEP_DLL_RST: begin
                            issue_en   = 1'b1;
                            issue_step = STEP_PRE_B;
                        end
                        STEP_PRE_B: begin
                            issue_en   = 1'b1;
                            issue_step = STEP_REFRESH;
                        end
                        STEP_REFRESH: begin
                            issue_en   = 1'b1;
                            issue_step = (seq_q.refs == REF_LAST) ? STEP_FINAL : STEP_REFRESH;
                        end
                        default: begin
                            issue_en = 1'b0;
                        end
                    endcase
                end
            end
            default: begin
                issue_en = 1'b0;
            end
        endcase
    end

    ddr_init_cmd_enc #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN),
        .BURST_TYPE(BURST_TYPE),
        .HALF_DRIVE(HALF_DRIVE)
    ) u_enc (
        .step_i(issue_step),
        .cmd_o (enc_cmd),
        .ba_o  (enc_ba),
        .addr_o(enc_addr)
    );

    ddr_init_dll_wait #(
        .T_DLL(T_DLL)
    ) u_dll (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(issue_en && (issue_step == STEP_DLL_RST)),
        .ready_o(dll_ready)
    );

    // Next state and next outputs
    always_comb begin
        seq_d      = seq_q;
        seq_d.cmd  = CMD_NOP;
        seq_d.ba   = 2'b00;
        seq_d.addr = '0;
        case (seq_q.phase)
            PH_STABLE: begin
                seq_d.cmd = CMD_DESEL;
                if (seq_q.cnt == STABLE_LAST) begin
                    seq_d.phase = PH_CKE;
                    seq_d.cnt   = '0;
                    seq_d.cke   = 1'b1;
                    seq_d.cmd   = CMD_NOP;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_CKE, PH_GAP: begin
                if (issue_en) begin
                    seq_d.phase = PH_GAP;
                    seq_d.step  = issue_step;
                    seq_d.cnt   = '0;
                    seq_d.cmd   = enc_cmd;
                    seq_d.ba    = enc_ba;
                    seq_d.addr  = enc_addr;
                    if (issue_step == STEP_REFRESH) begin
                        seq_d.refs = (seq_q.step == STEP_REFRESH) ? seq_q.refs + 1'b1 : '0;
                    end
                end else if ((seq_q.phase == PH_GAP) && (seq_q.step == STEP_FINAL) &&
                             (seq_q.cnt >= MRD_LAST) && dll_ready) begin
                    seq_d.phase = PH_DONE;
                    seq_d.done  = 1'b1;
                end else if (seq_q.cnt != CNT_TOP) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_STABLE;
            seq_q.step  <= STEP_PRE_A;
            seq_q.cnt   <= '0;
            seq_q.refs  <= '0;
            seq_q.cke   <= 1'b0;
            seq_q.cmd   <= CMD_DESEL;
            seq_q.ba    <= 2'b00;
            seq_q.addr  <= '0;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ddr_cke   = seq_q.cke;
    assign ddr_cs_n  = seq_q.cmd[3];
    assign ddr_ras_n = seq_q.cmd[2];
    assign ddr_cas_n = seq_q.cmd[1];
    assign ddr_we_n  = seq_q.cmd[0];
    assign ddr_ba    = seq_q.ba;
    assign ddr_addr  = seq_q.addr;
    assign init_done = seq_q.done;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int ADDR_W   = 13,
    parameter int T_STABLE = 20000,
    parameter int T_DLL    = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ddr_cke,
    input logic              ddr_cs_n,
    input logic              ddr_ras_n,
    input logic              ddr_cas_n,
    input logic              ddr_we_n,
    input logic [1:0]        ddr_ba,
    input logic [ADDR_W-1:0] ddr_addr,
    input logic              init_done
);

    logic [3:0] cmd;
    assign cmd = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};

    logic        is_mode, is_prech, is_dll_rst;
    assign is_mode    = (cmd == 4'b0000);
    assign is_prech   = (cmd == 4'b0010);
    assign is_dll_rst = is_mode && (ddr_ba == 2'b00) && ddr_addr[8];

    // Cycles spent with clock enable low since reset
    logic [31:0] low_cnt;
    // Cycles since the DLL-reset mode load
    logic [31:0] dll_cnt;
    logic        dll_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            dll_cnt  <= '0;
            dll_seen <= 1'b0;
        end else begin
            if (!ddr_cke && (low_cnt != 32'hFFFF_FFFF)) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (is_dll_rst) begin
                dll_cnt  <= 32'd1;
                dll_seen <= 1'b1;
            end else if (dll_seen && (dll_cnt != 32'hFFFF_FFFF)) begin
                dll_cnt <= dll_cnt + 1'b1;
            end
        end
    end

    assert_desel_while_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ddr_cke |-> ddr_cs_n);

    assert_cke_not_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ddr_cke) |-> (low_cnt >= 32'(T_STABLE)));

    assert_cke_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |=> ddr_cke);

    assert_prech_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_prech |-> ddr_addr[10]);

    assert_ext_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode && (ddr_ba == 2'b01)) |-> (!ddr_addr[0] && !ddr_addr[2]));

    assert_mode_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mode && (ddr_ba == 2'b00)) |-> (ddr_addr[6:4] == 3'b011));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_after_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (dll_seen && (dll_cnt >= 32'(T_DLL))));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (ddr_cke && (cmd == 4'b0111)));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
    .ADDR_W  (ADDR_W),
    .T_STABLE(T_STABLE),
    .T_DLL   (T_DLL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ddr_cke  (ddr_cke),
    .ddr_cs_n (ddr_cs_n),
    .ddr_ras_n(ddr_ras_n),
    .ddr_cas_n(ddr_cas_n),
    .ddr_we_n (ddr_we_n),
    .ddr_ba   (ddr_ba),
    .ddr_addr (ddr_addr),
    .init_done(init_done)
);

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;

    localparam int AW = 13;

    // Configuration A: DLL lock time decides the done cycle
    localparam int A_STABLE = 40, A_CKE = 2, A_RP = 3, A_MRD = 2, A_RFC = 6, A_DLL = 30, A_NREF = 2;
    localparam int A_BL = 4, A_BT = 1, A_HD = 1;
    // Configuration B: final mode gap decides the done cycle
    localparam int B_STABLE = 25, B_CKE = 3, B_RP = 2, B_MRD = 4, B_RFC = 5, B_DLL = 5, B_NREF = 3;
    localparam int B_BL = 8, B_BT = 0, B_HD = 0;

    logic clk;
    logic rst_n;

    logic          a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]    a_ba;
    logic [AW-1:0] a_addr;
    logic          b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]    b_ba;
    logic [AW-1:0] b_addr;

    int checks = 0;
    int errors = 0;

    initial clk = 1'b0;
    always #5 clk = ~clk;

    ddr_init_seq #(
        .ADDR_W(AW), .T_STABLE(A_STABLE), .T_CKE(A_CKE), .T_RP(A_RP), .T_MRD(A_MRD),
        .T_RFC(A_RFC), .T_DLL(A_DLL), .N_REF(A_NREF), .BURST_LEN(A_BL),
        .BURST_TYPE(A_BT), .HALF_DRIVE(A_HD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ddr_cke(a_cke), .ddr_cs_n(a_cs), .ddr_ras_n(a_ras),
        .ddr_cas_n(a_cas), .ddr_we_n(a_we), .ddr_ba(a_ba), .ddr_addr(a_addr), .init_done(a_done)
    );

    ddr_init_seq #(
        .ADDR_W(AW), .T_STABLE(B_STABLE), .T_CKE(B_CKE), .T_RP(B_RP), .T_MRD(B_MRD),
        .T_RFC(B_RFC), .T_DLL(B_DLL), .N_REF(B_NREF), .BURST_LEN(B_BL),
        .BURST_TYPE(B_BT), .HALF_DRIVE(B_HD)
    ) dut_alt (
        .clk(clk), .rst_n(rst_n), .ddr_cke(b_cke), .ddr_cs_n(b_cs), .ddr_ras_n(b_ras),
        .ddr_cas_n(b_cas), .ddr_we_n(b_we), .ddr_ba(b_ba), .ddr_addr(b_addr), .init_done(b_done)
    );

    typedef struct {
        int            cyc;
        logic [3:0]    cmd;
        logic [1:0]    ba;
        logic [AW-1:0] addr;
        int            tag;
    } exp_t;

    exp_t q_a[$];
    exp_t q_b[$];
    int   done_cyc[2];
    int   stable_of[2];
    int   cke_of[2];

    function automatic string tag_name(input int t);
        case (t)
            1:       return "R1";
            2:       return "R2";
            3:       return "R3";
            4:       return "R4";
            5:       return "R5";
            6:       return "R6";
            7:       return "R7";
            8:       return "R8";
            9:       return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic push_item(input int sel, input int cyc, input logic [3:0] cmd,
                             input logic [1:0] ba, input logic [AW-1:0] addr, input int tag);
        exp_t e;
        e.cyc = cyc; e.cmd = cmd; e.ba = ba; e.addr = addr; e.tag = tag;
        if (sel == 0) q_a.push_back(e);
        else          q_b.push_back(e);
    endtask

    // Driver: builds the expected command schedule from the requirements
    task automatic plan(input int sel);
        int ts, tc, trp, tmrd, trfc, tdll, nref, bl, bt, hd;
        int t, m;
        logic [2:0]    lc;
        logic [AW-1:0] mw;
        if (sel == 0) begin
            ts = A_STABLE; tc = A_CKE; trp = A_RP; tmrd = A_MRD; trfc = A_RFC;
            tdll = A_DLL; nref = A_NREF; bl = A_BL; bt = A_BT; hd = A_HD;
        end else begin
            ts = B_STABLE; tc = B_CKE; trp = B_RP; tmrd = B_MRD; trfc = B_RFC;
            tdll = B_DLL; nref = B_NREF; bl = B_BL; bt = B_BT; hd = B_HD;
        end
        stable_of[sel] = ts;
        cke_of[sel]    = tc;
        lc = (bl == 8) ? 3'b011 : (bl == 4) ? 3'b010 : 3'b001;
        mw = '0;
        mw[2:0] = lc;
        mw[3]   = 1'(bt);
        mw[6:4] = 3'b011;
        t = ts + tc;
        push_item(sel, t, 4'b0010, 2'b00, AW'(1 << 10), 4);            // R4 first precharge
        t += trp;
        push_item(sel, t, 4'b0000, 2'b01, AW'(hd << 1), 5);            // R5 extended load
        t += tmrd;
        m = t;
        push_item(sel, t, 4'b0000, 2'b00, mw | AW'(1 << 8), 6);        // R6 DLL reset load
        t += tmrd;
        push_item(sel, t, 4'b0010, 2'b00, AW'(1 << 10), 7);            // R7 precharge after gap
        t += trp;
        for (int i = 0; i < nref; i++) begin
            push_item(sel, t, 4'b0001, 2'b00, '0, 3);                  // R3 refresh order
            t += trfc;
        end
        push_item(sel, t, 4'b0000, 2'b00, mw, 6);                      // R6 final load
        done_cyc[sel] = ((t + tmrd) > (m + tdll)) ? (t + tmrd) : (m + tdll);
    endtask

    // Monitor: one instance, one cycle
    task automatic check_one(input int sel, input int cyc, input logic cke, input logic [3:0] cmd,
                             input logic [1:0] ba, input logic [AW-1:0] addr, input logic done);
        logic          e_cke;
        logic [3:0]    e_cmd;
        logic [1:0]    e_ba;
        logic [AW-1:0] e_addr;
        int            tag;
        exp_t          e;
        logic          hit;
        e_cke = (cyc >= stable_of[sel]);
        e_cmd = e_cke ? 4'b0111 : 4'b1111;
        e_ba  = 2'b00;
        e_addr = '0;
        tag = (cyc < stable_of[sel]) ? 1 : (cyc < stable_of[sel] + cke_of[sel]) ? 2 : 9;
        hit = 1'b0;
        if (sel == 0) begin
            if (q_a.size() > 0 && q_a[0].cyc == cyc) begin e = q_a.pop_front(); hit = 1'b1; end
        end else begin
            if (q_b.size() > 0 && q_b[0].cyc == cyc) begin e = q_b.pop_front(); hit = 1'b1; end
        end
        if (hit) begin
            e_cmd = e.cmd; e_ba = e.ba; e_addr = e.addr; tag = e.tag;
        end
        checks++;
        if (cke !== e_cke || cmd !== e_cmd || ba !== e_ba || addr !== e_addr) begin
            errors++;
            $display("FAIL %s inst%0d cycle %0d: got cke=%b cmd=%b ba=%b addr=%h, expected cke=%b cmd=%b ba=%b addr=%h",
                     tag_name(tag), sel, cyc, cke, cmd, ba, addr, e_cke, e_cmd, e_ba, e_addr);
        end
        checks++;
        if (done !== (cyc >= done_cyc[sel])) begin
            errors++;
            $display("FAIL R8 inst%0d cycle %0d: got done=%b expected %b",
                     sel, cyc, done, (cyc >= done_cyc[sel]));
        end
    endtask

    task automatic run_cycles(input int n);
        for (int cyc = 0; cyc < n; cyc++) begin
            #1;
            check_one(0, cyc, a_cke, {a_cs, a_ras, a_cas, a_we}, a_ba, a_addr, a_done);
            check_one(1, cyc, b_cke, {b_cs, b_ras, b_cas, b_we}, b_ba, b_addr, b_done);
            @(negedge clk);
        end
    endtask

    task automatic check_in_reset();
        #1;
        checks++;
        if (a_cke !== 1'b0 || a_cs !== 1'b1 || a_done !== 1'b0 ||
            b_cke !== 1'b0 || b_cs !== 1'b1 || b_done !== 1'b0) begin
            errors++;
            $display("FAIL R10 in reset: got cke=%b/%b cs_n=%b/%b done=%b/%b expected 0/0 1/1 0/0",
                     a_cke, b_cke, a_cs, b_cs, a_done, b_done);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_in_reset();
        // Phase 1: partial run, then reset in the middle of the sequence (R10)
        plan(0);
        plan(1);
        rst_n = 1'b1;
        run_cycles(50);
        rst_n = 1'b0;
        check_in_reset();
        q_a.delete();
        q_b.delete();
        repeat (3) @(negedge clk);
        check_in_reset();
        // Phase 2: full run from scratch after reset (R10, R1..R9)
        plan(0);
        plan(1);
        rst_n = 1'b1;
        run_cycles(110);
        checks++;
        if (q_a.size() != 0 || q_b.size() != 0) begin
            errors++;
            $display("FAIL R3 commands missing: got %0d/%0d pending expected 0/0", q_a.size(), q_b.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule